// File: doc/BRIEF.md
# Prioritized Interrupt Vector Resolver

This block sits between the request lines of a small microcontroller and its CPU core. Every clock it captures the reset-class causes, the non-maskable pin request, the external maskable pin request and a bank of on-chip peripheral requests. It also captures the local enables and the two condition-code mask bits. From these it decides which single request is eligible and ranks highest. It then presents the 16-bit address of that request's two-byte vector, together with a valid flag.

The ranking is fixed and has 17 levels. Reset-class causes ignore all masking. The non-maskable request has a mask class of its own. The external pin and the peripheral sources all share the I mask. The CPU core uses the output when it decides to take an exception. The core, its stacking sequence and the request-generating peripherals lie outside this block. The software-trap and illegal-opcode vectors are resolved at instruction level, so they never appear on this output.

Top module: `ivr_resolver`

## Requirements
- R1: When `rst_cause` is set, the vector is 0xFFFE and valid is high, whatever the state of every other input and mask.
- R2: The clock-monitor source is eligible only while `cmf_en` is 1. Its vector is 0xFFFC, and it outranks every source except R1.
- R3: The watchdog source is eligible only while `cop_off` is 0. Its vector is 0xFFFA, and it outranks the pin and peripheral sources.
- R4: The non-maskable pin request (`xirq_req`) is blocked only by `x_mask`=1, and `i_mask` has no effect on it. Its vector is 0xFFF4, and it outranks `irq_req`.
- R5: The external pin request (`irq_req`) is blocked only by `i_mask`=1. It has no local enable. Its vector is 0xFFF2, and it outranks every peripheral source.
- R6: Peripheral bit k is eligible only when `periph_req[k]`=1, `periph_en[k]`=1 and `i_mask`=0. Its vector is 0xFFF0 minus 2k. The bit order is: 0 real-time tick, 1 to 3 capture 1 to 3, 4 to 7 compare 1 to 4, 8 capture 4/compare 5, 9 timer overflow, 10 pulse-count overflow, 11 pulse-count edge.
- R7: Among eligible peripheral sources, the lowest bit index wins. Across all classes, the order is R1 > R2 > R3 > R4 > R5 > R6.
- R8: With no eligible source, valid is low and the vector is 0x0000.
- R9: The outputs reflect the inputs sampled at the most recent rising clock edge, which is one cycle of latency. The path from the sampled inputs to the outputs is combinational.
- R10: While `rst_n` is low, valid is low and the vector is 0x0000.
- R11: The vectors 0xFFF6 and 0xFFF8 are never produced, and every produced vector is even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| rst_cause | input | 1 | Reset-class cause, unmaskable |
| cmf_req | input | 1 | Clock-monitor failure request |
| cmf_en | input | 1 | Clock-monitor enable |
| cop_req | input | 1 | Watchdog timeout request |
| cop_off | input | 1 | Watchdog disable control |
| xirq_req | input | 1 | Non-maskable pin request |
| x_mask | input | 1 | X condition-code mask bit |
| irq_req | input | 1 | External maskable pin request |
| i_mask | input | 1 | I condition-code mask bit |
| periph_req | input | NUM_PERIPH | On-chip peripheral requests, bit 0 highest |
| periph_en | input | NUM_PERIPH | Local enables for the peripheral requests |
| vec_valid | output | 1 | A source is eligible |
| vec_addr | output | ADDR_W | Vector fetch address, zero when idle |

## Verification
Each result is due exactly one rising edge after its stimulus is applied. Inputs are driven on a falling edge, captured at the next rising edge, and appear on the outputs by the following falling edge. The driver tags every expected item with the cycle count at which it falls due. The monitor compares only the items whose due count matches the current falling edge, so back-to-back stimuli in consecutive cycles are each checked against their own result. The block reset is checked asynchronously, a short delay after `rst_n` falls.

// File: rtl/ivr_pkg.sv
package ivr_pkg;

   localparam int FIXED_LEVELS = 5;

   typedef enum int {
      LVL_RESET    = 0,
      LVL_CLKMON   = 1,
      LVL_WATCHDOG = 2,
      LVL_NMI      = 3,
      LVL_EXTPIN   = 4
   } fixed_lvl_e;

   localparam logic [15:0] VEC_RESET      = 16'hFFFE;
   localparam logic [15:0] VEC_CLKMON     = 16'hFFFC;
   localparam logic [15:0] VEC_WATCHDOG   = 16'hFFFA;
   localparam logic [15:0] VEC_ILLOP      = 16'hFFF8;
   localparam logic [15:0] VEC_SWTRAP     = 16'hFFF6;
   localparam logic [15:0] VEC_NMI        = 16'hFFF4;
   localparam logic [15:0] VEC_EXTPIN     = 16'hFFF2;
   localparam logic [15:0] VEC_PERIPH_TOP = 16'hFFF0;
   localparam int          VEC_STEP       = 2;

   function automatic logic [15:0] periph_vector(input int k);
      return VEC_PERIPH_TOP - 16'(VEC_STEP * k);
   endfunction

   function automatic logic [15:0] fixed_vector(input int lvl);
      logic [15:0] v;
      case (lvl)
         LVL_RESET:    v = VEC_RESET;
         LVL_CLKMON:   v = VEC_CLKMON;
         LVL_WATCHDOG: v = VEC_WATCHDOG;
         LVL_NMI:      v = VEC_NMI;
         default:      v = VEC_EXTPIN;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/ivr_capture.sv
module ivr_capture #(
   parameter int W         = 8,
   parameter bit REGISTER  = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (REGISTER) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end
      end else begin : g_pass
         logic unused_clk;
         assign unused_clk = clk;
         assign q = rst_n ? d : '0;
      end
   endgenerate

endmodule

// File: rtl/ivr_qualify.sv
module ivr_qualify
   import ivr_pkg::*;
#(
   parameter int NUM_PERIPH = 12,
   localparam int NLEV      = FIXED_LEVELS + NUM_PERIPH
) (
   input  logic                  rst_cause,
   input  logic                  cmf_req,
   input  logic                  cmf_en,
   input  logic                  cop_req,
   input  logic                  cop_off,
   input  logic                  xirq_req,
   input  logic                  x_mask,
   input  logic                  irq_req,
   input  logic                  i_mask,
   input  logic [NUM_PERIPH-1:0] periph_req,
   input  logic [NUM_PERIPH-1:0] periph_en,
   output logic [NLEV-1:0]       elig
);

   assign elig[LVL_RESET]    = rst_cause;
   assign elig[LVL_CLKMON]   = cmf_req & cmf_en;
   assign elig[LVL_WATCHDOG] = cop_req & ~cop_off;
   assign elig[LVL_NMI]      = xirq_req & ~x_mask;
   assign elig[LVL_EXTPIN]   = irq_req & ~i_mask;

   generate
      for (genvar k = 0; k < NUM_PERIPH; k++) begin : g_periph
         assign elig[FIXED_LEVELS + k] = periph_req[k] & periph_en[k] & ~i_mask;
      end
   endgenerate

endmodule

// File: rtl/ivr_pick.sv
module ivr_pick #(
   parameter int N   = 17,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  grant,
   output logic [IW-1:0] idx,
   output logic          any
);

   logic [N:0] taken;
   assign taken[0] = 1'b0;

   generate
      for (genvar i = 0; i < N; i++) begin : g_chain
         assign grant[i]   = req[i] & ~taken[i];
         assign taken[i+1] = taken[i] | req[i];
      end
   endgenerate

   assign any = taken[N];

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) idx = idx | IW'(i);
      end
   end

endmodule

// File: rtl/ivr_vecmap.sv
module ivr_vecmap
   import ivr_pkg::*;
#(
   parameter int NLEV   = 17,
   parameter int ADDR_W = 16,
   localparam int IW    = (NLEV > 1) ? $clog2(NLEV) : 1
) (
   input  logic [IW-1:0]     idx,
   input  logic              any,
   output logic [ADDR_W-1:0] addr
);

   logic [15:0] raw;

   always_comb begin
      if (int'(idx) < FIXED_LEVELS) raw = fixed_vector(int'(idx));
      else                          raw = periph_vector(int'(idx) - FIXED_LEVELS);
   end

   assign addr = any ? ADDR_W'(raw) : '0;

endmodule

// File: rtl/ivr_resolver.sv
module ivr_resolver
   import ivr_pkg::*;
#(
   parameter int NUM_PERIPH = 12,
   parameter int ADDR_W     = 16,
   parameter bit IN_REG     = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rst_cause,
   input  logic                  cmf_req,
   input  logic                  cmf_en,
   input  logic                  cop_req,
   input  logic                  cop_off,
   input  logic                  xirq_req,
   input  logic                  x_mask,
   input  logic                  irq_req,
   input  logic                  i_mask,
   input  logic [NUM_PERIPH-1:0] periph_req,
   input  logic [NUM_PERIPH-1:0] periph_en,
   output logic                  vec_valid,
   output logic [ADDR_W-1:0]     vec_addr
);

   localparam int NLEV  = FIXED_LEVELS + NUM_PERIPH;
   localparam int IW    = $clog2(NLEV);
   localparam int CAP_W = 9 + 2 * NUM_PERIPH;

   generate
      if (NUM_PERIPH < 1 || NUM_PERIPH > 24) begin : g_bad_periph
         $error("ivr_resolver: NUM_PERIPH must lie in 1..24");
      end
      if (ADDR_W < 16) begin : g_bad_addr
         $error("ivr_resolver: ADDR_W must be at least 16");
      end
   endgenerate

   logic [CAP_W-1:0] cap_d, cap_q;

   assign cap_d = {periph_en, periph_req, i_mask, irq_req, x_mask, xirq_req,
                   cop_off, cop_req, cmf_en, cmf_req, rst_cause};

   ivr_capture #(.W(CAP_W), .REGISTER(IN_REG)) i_capture (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cap_d),
      .q     (cap_q)
   );

   logic [NLEV-1:0] elig;

   ivr_qualify #(.NUM_PERIPH(NUM_PERIPH)) i_qualify (
      .rst_cause  (cap_q[0]),
      .cmf_req    (cap_q[1]),
      .cmf_en     (cap_q[2]),
      .cop_req    (cap_q[3]),
      .cop_off    (cap_q[4]),
      .xirq_req   (cap_q[5]),
      .x_mask     (cap_q[6]),
      .irq_req    (cap_q[7]),
      .i_mask     (cap_q[8]),
      .periph_req (cap_q[9 +: NUM_PERIPH]),
      .periph_en  (cap_q[9 + NUM_PERIPH +: NUM_PERIPH]),
      .elig       (elig)
   );

   logic [NLEV-1:0] grant;
   logic [IW-1:0]   win_idx;
   logic            win_any;

   ivr_pick #(.N(NLEV)) i_pick (
      .req   (elig),
      .grant (grant),
      .idx   (win_idx),
      .any   (win_any)
   );

   logic unused_grant;
   assign unused_grant = ^grant;

   ivr_vecmap #(.NLEV(NLEV), .ADDR_W(ADDR_W)) i_vecmap (
      .idx  (win_idx),
      .any  (win_any),
      .addr (vec_addr)
   );

   assign vec_valid = win_any;

endmodule

// File: rtl/ivr_resolver_chk.sv
module ivr_resolver_chk #(
   parameter int NUM_PERIPH = 12,
   parameter int ADDR_W     = 16,
   parameter bit IN_REG     = 1'b1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  rst_cause,
   input logic                  cmf_req,
   input logic                  cmf_en,
   input logic                  cop_req,
   input logic                  cop_off,
   input logic                  xirq_req,
   input logic                  x_mask,
   input logic                  irq_req,
   input logic                  i_mask,
   input logic [NUM_PERIPH-1:0] periph_req,
   input logic [NUM_PERIPH-1:0] periph_en,
   input logic                  vec_valid,
   input logic [ADDR_W-1:0]     vec_addr
);

   // R10: block reset clears the outputs
   a_r10_reset_idle: assert property (@(posedge clk)
      !rst_n |-> (!vec_valid && vec_addr == '0));

   // R11: trap vectors never appear and addresses are even
   a_r11_no_trap_vec: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> (vec_addr != ADDR_W'(16'hFFF6) && vec_addr != ADDR_W'(16'hFFF8)
                     && !vec_addr[0]));

   generate
      if (IN_REG) begin : g_timed
         // R1 with R9 latency
         a_r1_reset_vec: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(rst_cause)) |->
               (vec_valid && vec_addr == ADDR_W'(16'hFFFE)));

         // R3
         a_r3_watchdog: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(!rst_cause && !(cmf_req && cmf_en) && cop_req && !cop_off))
               |-> (vec_valid && vec_addr == ADDR_W'(16'hFFFA)));

         // R4
         a_r4_xmask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(x_mask)) |-> (vec_addr != ADDR_W'(16'hFFF4)));

         // R5
         a_r5_imask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(i_mask && !rst_cause && !(cmf_req && cmf_en)
                                   && !(cop_req && !cop_off) && !(xirq_req && !x_mask)))
               |-> !vec_valid);

         // R8
         a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(!rst_cause && !cmf_req && !cop_req && !xirq_req
                                   && !irq_req && periph_req == '0))
               |-> (!vec_valid && vec_addr == '0));
      end
   endgenerate

endmodule

bind ivr_resolver ivr_resolver_chk #(
   .NUM_PERIPH (NUM_PERIPH),
   .ADDR_W     (ADDR_W),
   .IN_REG     (IN_REG)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rst_cause  (rst_cause),
   .cmf_req    (cmf_req),
   .cmf_en     (cmf_en),
   .cop_req    (cop_req),
   .cop_off    (cop_off),
   .xirq_req   (xirq_req),
   .x_mask     (x_mask),
   .irq_req    (irq_req),
   .i_mask     (i_mask),
   .periph_req (periph_req),
   .periph_en  (periph_en),
   .vec_valid  (vec_valid),
   .vec_addr   (vec_addr)
);

// File: tb/test_ivr_resolver.sv
`timescale 1ns/1ps
module test_ivr_resolver;

   localparam int NP = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rst_cause = 0, cmf_req = 0, cmf_en = 0, cop_req = 0, cop_off = 0;
   logic xirq_req = 0, x_mask = 0, irq_req = 0, i_mask = 0;
   logic [NP-1:0] periph_req = '0, periph_en = '0;
   logic vec_valid;
   logic [15:0] vec_addr;

   always #2 clk = ~clk;

   ivr_resolver #(.NUM_PERIPH(NP), .ADDR_W(16), .IN_REG(1'b1)) i_ivr_resolver (
      .clk(clk), .rst_n(rst_n), .rst_cause(rst_cause), .cmf_req(cmf_req),
      .cmf_en(cmf_en), .cop_req(cop_req), .cop_off(cop_off), .xirq_req(xirq_req),
      .x_mask(x_mask), .irq_req(irq_req), .i_mask(i_mask), .periph_req(periph_req),
      .periph_en(periph_en), .vec_valid(vec_valid), .vec_addr(vec_addr)
   );

   int n_checks = 0;
   int n_errors = 0;
   int cyc = 0;
   bit finished = 0;

   int          q_due[$];
   logic [16:0] q_exp[$];
   string       q_tag[$];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   function automatic logic [16:0] model(
      input logic rc, cf, ce, cp, co, xr, xm, ir, im,
      input logic [NP-1:0] pr, pe);
      if (rc)       return {1'b1, 16'hFFFE};
      if (cf && ce) return {1'b1, 16'hFFFC};
      if (cp && !co) return {1'b1, 16'hFFFA};
      if (xr && !xm) return {1'b1, 16'hFFF4};
      if (!im) begin
         if (ir) return {1'b1, 16'hFFF2};
         for (int k = 0; k < NP; k++)
            if (pr[k] && pe[k]) return {1'b1, 16'hFFF0 - 16'(2 * k)};
      end
      return 17'h0;
   endfunction

   task automatic check(input string tag, input logic [16:0] got, input logic [16:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: got valid=%0b addr=%h, expected valid=%0b addr=%h",
                  tag, got[16], got[15:0], exp[16], exp[15:0]);
      end
   endtask

   // driver: apply one stimulus for one cycle, push expectation
   task automatic drive(input logic rc, cf, ce, cp, co, xr, xm, ir, im,
                        input logic [NP-1:0] pr, pe, input string tag);
      @(negedge clk);
      rst_cause = rc; cmf_req = cf; cmf_en = ce; cop_req = cp; cop_off = co;
      xirq_req = xr; x_mask = xm; irq_req = ir; i_mask = im;
      periph_req = pr; periph_en = pe;
      q_due.push_back(cyc + 1);
      q_exp.push_back(model(rc, cf, ce, cp, co, xr, xm, ir, im, pr, pe));
      q_tag.push_back(tag);
   endtask

   // monitor: R9 one-cycle latency, compare items falling due now
   always @(negedge clk) begin
      if (rst_n) begin
         while (q_due.size() > 0 && q_due[0] == cyc) begin
            check(q_tag[0], {vec_valid, vec_addr}, q_exp[0]);
            if (vec_valid && (vec_addr == 16'hFFF6 || vec_addr == 16'hFFF8)) begin
               n_errors++;
               $display("FAIL R11: got addr=%h, expected not a trap vector", vec_addr);
            end
            void'(q_due.pop_front());
            void'(q_exp.pop_front());
            void'(q_tag.pop_front());
         end
      end
   end

   task automatic drain();
      repeat (3) @(negedge clk);
   endtask

   localparam logic [NP-1:0] ALL = '1;
   localparam logic [NP-1:0] NONE = '0;

   initial begin
      #2000000;
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R10 reset state", {vec_valid, vec_addr}, 17'h0);
      rst_n = 1'b1;

      // R8 idle
      drive(0,0,0,0,0,0,0,0,0, NONE, ALL, "R8 idle");
      drive(0,0,0,0,0,0,1,0,1, NONE, NONE, "R8 idle masked");
      // single sources
      drive(1,0,0,0,0,0,1,0,1, NONE, NONE, "R1 reset alone");
      drive(1,1,1,1,0,1,0,1,0, ALL, ALL, "R1 reset over all");
      drive(0,1,1,0,0,0,0,0,0, NONE, NONE, "R2 clkmon enabled");
      drive(0,1,0,0,0,0,0,0,0, NONE, NONE, "R2 clkmon disabled");
      drive(0,1,1,1,0,1,0,1,0, ALL, ALL, "R2 clkmon over lower");
      drive(0,0,0,1,0,0,0,0,0, NONE, NONE, "R3 watchdog");
      drive(0,0,0,1,1,0,0,0,0, NONE, NONE, "R3 watchdog off");
      drive(0,0,0,1,0,1,0,1,0, ALL, ALL, "R3 watchdog over pins");
      drive(0,0,0,0,0,1,0,0,0, NONE, NONE, "R4 xirq");
      drive(0,0,0,0,0,1,1,0,0, NONE, NONE, "R4 xirq masked");
      drive(0,0,0,0,0,1,0,0,1, NONE, NONE, "R4 xirq ignores I");
      drive(0,0,0,0,0,1,0,1,0, ALL, ALL, "R4 xirq over irq");
      drive(0,0,0,0,0,1,1,1,0, NONE, NONE, "R5 irq with X set");
      drive(0,0,0,0,0,0,0,1,0, NONE, NONE, "R5 irq");
      drive(0,0,0,0,0,0,0,1,1, NONE, NONE, "R5 irq masked");
      drive(0,0,0,0,0,0,0,1,0, ALL, ALL, "R5 irq over periph");
      for (int k = 0; k < NP; k++) begin
         drive(0,0,0,0,0,0,0,0,0, NP'(1) << k, ALL, $sformatf("R6 periph %0d", k));
         drive(0,0,0,0,0,0,0,0,0, NP'(1) << k, ~(NP'(1) << k), $sformatf("R6 periph %0d disabled", k));
         drive(0,0,0,0,0,0,0,0,1, NP'(1) << k, ALL, $sformatf("R6 periph %0d I set", k));
      end
      for (int k = 0; k < NP - 1; k++)
         drive(0,0,0,0,0,0,0,0,0, (NP'(3) << k), ALL, $sformatf("R7 pair %0d", k));
      drive(0,0,0,0,0,0,0,0,0, ALL, 12'hF00, "R7 lowest enabled wins");
      // R9 back-to-back changes each cycle
      drive(0,0,0,1,0,0,0,0,0, NONE, NONE, "R9 step a");
      drive(0,0,0,0,0,0,0,0,0, NONE, NONE, "R9 step b");
      drive(0,0,0,0,0,0,0,0,0, 12'h010, ALL, "R9 step c");
      // random combos against the reference model
      for (int n = 0; n < 500; n++) begin
         logic [NP-1:0] pr, pe;
         pr = NP'($urandom) & NP'($urandom);
         pe = NP'($urandom);
         drive(($urandom % 16) == 0, ($urandom % 6) == 0, $urandom % 2,
               ($urandom % 6) == 0, $urandom % 2, ($urandom % 5) == 0, $urandom % 2,
               ($urandom % 4) == 0, ($urandom % 3) == 0, pr, pe, "R7 random");
      end
      drive(0,0,0,0,0,0,0,0,0, NONE, NONE, "R8 idle end");
      drain();
      if (q_due.size() != 0) begin
         n_checks++;
         n_errors++;
         $display("FAIL R9: got %0d pending results, expected 0", q_due.size());
      end
      // R10 async reset with a request held
      @(negedge clk);
      rst_cause = 1'b1;
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R10 reset clears", {vec_valid, vec_addr}, 17'h0);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule